// File: doc/BRIEF.md
# Receive Self-Test Compare Monitor

This block watches a stream of received characters that have already been decoded and checks them against a self-test pattern that it generates itself. It reports how the check is going as a 3-bit status code. For each character it compares, it gives a one-cycle pulse: one pulse for a match and another for an error. It sits after the character decoder and the elasticity buffer in a receive lane. It takes a lock indication from the clock-recovery loop and a fault strobe from the elasticity buffer.

After it is enabled, the monitor waits for the start character of the pattern, which is a data byte of zero. It then loads its pattern generator from the seed and compares every valid character that follows. It keeps a running balance of errors against matches. If the link drifts badly, it drops back to hunting for the start character. Loss of lock and buffer faults each override the compare. A buffer fault also keeps the monitor parked until nine more characters have passed.

Top module: `rx_selftest_monitor`

## Requirements
- R1: While reset is high, or one clock after enable goes low, the status is 3'b111 and both pulses are low. Disabling also clears the balance and the recentering hold, so after re-enable the first valid character leaves the start state with no hold.
- R2: The status takes only these codes: 000 start, 001 waiting for the start character, 010 comparing with the last character good, 011 comparing with the last character in error, 100 pattern wrap, 111 disabled.
- R3: One clock after enable rises, the status is 000. In the start state with no hold pending, the next valid character moves the status to 001.
- R4: In the wait state, a valid character with byte 0x00 and the control flag at 0 moves the status to 010 and counts as pattern index 0. Any other character, including byte 0x00 with the control flag at 1, leaves the status at 001. The start and wait states never pulse.
- R5: The pattern register is 9 bits, seeded with 0x100. The expected byte is its low 8 bits. It advances once per compared character as s <= {s[7:0], s[8]^s[4]}, which gives a 511-character period.
- R6: In a compare state (010, 011 or 100), a valid character with the control flag at 0 and the expected byte is a match: it sets status 010 and pulses match. Any other valid character is an error: it sets status 011 and pulses error. Status and pulses update at the clock edge that samples the character. A cycle without a valid character changes nothing.
- R7: A match on pattern index 510 sets status 100. The next character is expected to be index 0 again, which is byte 0x00.
- R8: A 6-bit balance goes up by one on each error and down by one on each match, and never goes below zero. An error that takes it above 16 moves the status to 001. The balance is cleared whenever the monitor enters the start or wait state.
- R9: While enabled, lock at 0 sets status 000 at the next clock from any state. It also clears the balance and the hold and suppresses both pulses.
- R10: A buffer fault sets status 000 at the next clock and loads a hold of 9. Each valid character decrements the hold while the status stays 000. Once the hold is zero, the next valid character moves the status to 001.
- R11: In the same cycle, loss of lock takes priority over a buffer fault, and a buffer fault takes priority over the error threshold and the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enables the compare monitor |
| lock_i | input | 1 | Receive clock-recovery lock, 1 = locked |
| eb_fault_i | input | 1 | Elasticity buffer overflow or underflow event |
| char_valid_i | input | 1 | Character strobe for this cycle |
| char_ctl_i | input | 1 | 1 = control character, 0 = data character |
| char_byte_i | input | DATA_W | Decoded character byte |
| status_o | output | 3 | Compare state code |
| err_o | output | 1 | One-cycle pulse for a compared error |
| match_o | output | 1 | One-cycle pulse for a compared match |

## Verification
The bench drives the full 511-character pattern to reach the wrap code. A generator with the wrong taps or the wrong index limit would miss the 100 code or would expect a nonzero byte after the wrap. It loads the balance to exactly 16 errors, both after a run of matches and after a single match. This exposes a balance that underflows, resyncs one error early or late, or ignores matches. It raises a buffer fault together with the threshold-crossing error, and loss of lock together with a buffer fault, to catch a wrong priority. A design with the wrong priority would resync instead of parking, or would load a hold that lock loss should clear. It also counts exactly nine characters through the hold with idle cycles mixed in. A zero byte flagged as control in the wait state shows whether the control flag is checked.

// File: rtl/rxst_pkg.sv
`timescale 1ns/1ps
package rxst_pkg;
   typedef enum logic [2:0] {
      ST_START = 3'b000,
      ST_WAIT  = 3'b001,
      ST_GOOD  = 3'b010,
      ST_BAD   = 3'b011,
      ST_WRAP  = 3'b100,
      ST_OFF   = 3'b111
   } rxst_code_e;
endpackage

// File: rtl/rxst_pattern_gen.sv
`timescale 1ns/1ps
// Self-test pattern source: shift register plus a position index.
module rxst_pattern_gen #(
   parameter int LFSR_W  = 9,
   parameter int DATA_W  = 8,
   parameter int TAP_BIT = 4,
   parameter int SEED    = 256
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              restart_i,
   input  logic              advance_i,
   output logic [DATA_W-1:0] exp_o,
   output logic              last_o
);
   localparam int SEQ_LEN = (1 << LFSR_W) - 1;
   localparam logic [LFSR_W-1:0] SEED_V   = LFSR_W'(SEED);
   localparam logic [LFSR_W-1:0] LAST_IDX = LFSR_W'(SEQ_LEN - 1);

   if (DATA_W >= LFSR_W) begin : g_bad_width
      $error("pattern byte must be narrower than the shift register");
   end
   if (TAP_BIT >= LFSR_W - 1) begin : g_bad_tap
      $error("tap position out of range");
   end
   if (SEED_V == '0 || SEED_V[DATA_W-1:0] != '0) begin : g_bad_seed
      $error("seed must be nonzero with a zero first byte");
   end

   logic [LFSR_W-1:0] sr_q, sr_step, seed_step, idx_q;

   assign sr_step[0]   = sr_q[LFSR_W-1] ^ sr_q[TAP_BIT];
   assign seed_step[0] = SEED_V[LFSR_W-1] ^ SEED_V[TAP_BIT];
   for (genvar i = 1; i < LFSR_W; i++) begin : g_shift
      assign sr_step[i]   = sr_q[i-1];
      assign seed_step[i] = SEED_V[i-1];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sr_q  <= SEED_V;
         idx_q <= '0;
      end else if (restart_i) begin
         sr_q  <= seed_step;
         idx_q <= LFSR_W'(1);
      end else if (advance_i) begin
         sr_q  <= sr_step;
         idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
   end

   assign exp_o  = sr_q[DATA_W-1:0];
   assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/rxst_balance.sv
`timescale 1ns/1ps
// Error-minus-match balance, floored at zero, saturating at the top.
module rxst_balance #(
   parameter int BAL_W = 6,
   parameter int LIMIT = 16
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clear_i,
   input  logic up_i,
   input  logic down_i,
   output logic trip_o
);
   localparam logic [BAL_W-1:0] LIM_V = BAL_W'(LIMIT);
   localparam logic [BAL_W-1:0] MAX_V = '1;

   if (LIMIT + 1 > (1 << BAL_W) - 1) begin : g_bad_limit
      $error("balance too narrow for the limit");
   end

   logic [BAL_W-1:0] cnt_q;

   assign trip_o = up_i && (cnt_q >= LIM_V);

   always_ff @(posedge clk_i) begin
      if (rst_i || clear_i)             cnt_q <= '0;
      else if (up_i && cnt_q != MAX_V)  cnt_q <= cnt_q + 1'b1;
      else if (down_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/rxst_hold.sv
`timescale 1ns/1ps
// Recentering hold: loaded on a buffer fault, counted down on characters.
module rxst_hold #(
   parameter int HOLD_W = 4,
   parameter int LOAD   = 9
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clear_i,
   input  logic load_i,
   input  logic tick_i,
   output logic busy_o
);
   if (LOAD >= (1 << HOLD_W) || LOAD < 1) begin : g_bad_load
      $error("hold load does not fit the counter");
   end

   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clear_i)           cnt_q <= '0;
      else if (load_i)                cnt_q <= HOLD_W'(LOAD);
      else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rx_selftest_monitor.sv
`timescale 1ns/1ps
module rx_selftest_monitor #(
   parameter int DATA_W    = 8,
   parameter int LFSR_W    = 9,
   parameter int TAP_BIT   = 4,
   parameter int SEED      = 256,
   parameter int BAL_W     = 6,
   parameter int ERR_LIMIT = 16,
   parameter int HOLD_W    = 4,
   parameter int HOLD_LOAD = 9
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic              lock_i,
   input  logic              eb_fault_i,
   input  logic              char_valid_i,
   input  logic              char_ctl_i,
   input  logic [DATA_W-1:0] char_byte_i,
   output logic [2:0]        status_o,
   output logic              err_o,
   output logic              match_o
);
   import rxst_pkg::*;

   rxst_code_e        state_q, state_d;
   logic              err_d, match_d;
   logic              gen_restart, gen_advance, gen_last;
   logic [DATA_W-1:0] gen_exp;
   logic              bal_clear, bal_up, bal_down, bal_trip;
   logic              hold_clear, hold_load, hold_tick, hold_busy;
   logic              data_char, is_hit, is_sync, comparing;

   rxst_pattern_gen #(.LFSR_W(LFSR_W), .DATA_W(DATA_W), .TAP_BIT(TAP_BIT), .SEED(SEED)) u_gen (
      .clk_i(clk_i), .rst_i(rst_i), .restart_i(gen_restart),
      .advance_i(gen_advance), .exp_o(gen_exp), .last_o(gen_last));

   rxst_balance #(.BAL_W(BAL_W), .LIMIT(ERR_LIMIT)) u_bal (
      .clk_i(clk_i), .rst_i(rst_i), .clear_i(bal_clear),
      .up_i(bal_up), .down_i(bal_down), .trip_o(bal_trip));

   rxst_hold #(.HOLD_W(HOLD_W), .LOAD(HOLD_LOAD)) u_hold (
      .clk_i(clk_i), .rst_i(rst_i), .clear_i(hold_clear),
      .load_i(hold_load), .tick_i(hold_tick), .busy_o(hold_busy));

   assign data_char = char_valid_i && !char_ctl_i;
   assign is_hit    = data_char && (char_byte_i == gen_exp);
   assign is_sync   = data_char && (char_byte_i == '0);
   assign comparing = (state_q == ST_GOOD) || (state_q == ST_BAD) || (state_q == ST_WRAP);

   always_comb begin
      state_d     = state_q;
      err_d       = 1'b0;
      match_d     = 1'b0;
      gen_restart = 1'b0;
      gen_advance = 1'b0;
      bal_clear   = 1'b0;
      bal_up      = 1'b0;
      bal_down    = 1'b0;
      hold_clear  = 1'b0;
      hold_load   = 1'b0;
      hold_tick   = 1'b0;
      if (!en_i) begin
         state_d    = ST_OFF;
         bal_clear  = 1'b1;
         hold_clear = 1'b1;
      end else if (!lock_i) begin
         state_d    = ST_START;
         bal_clear  = 1'b1;
         hold_clear = 1'b1;
      end else if (eb_fault_i) begin
         state_d   = ST_START;
         bal_clear = 1'b1;
         hold_load = 1'b1;
      end else if (state_q == ST_OFF) begin
         state_d = ST_START;
      end else if (state_q == ST_START) begin
         if (char_valid_i) begin
            if (hold_busy) hold_tick = 1'b1;
            else begin
               state_d   = ST_WAIT;
               bal_clear = 1'b1;
            end
         end
      end else if (state_q == ST_WAIT) begin
         if (is_sync) begin
            state_d     = ST_GOOD;
            gen_restart = 1'b1;
         end
      end else if (comparing && char_valid_i) begin
         gen_advance = 1'b1;
         if (is_hit) begin
            match_d  = 1'b1;
            bal_down = 1'b1;
            state_d  = gen_last ? ST_WRAP : ST_GOOD;
         end else begin
            err_d  = 1'b1;
            bal_up = 1'b1;
            if (bal_trip) begin
               state_d   = ST_WAIT;
               bal_clear = 1'b1;
            end else begin
               state_d = ST_BAD;
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_OFF;
         err_o   <= 1'b0;
         match_o <= 1'b0;
      end else begin
         state_q <= state_d;
         err_o   <= err_d;
         match_o <= match_d;
      end
   end

   assign status_o = state_q;
endmodule

// File: rtl/rxst_sva.sv
`timescale 1ns/1ps
module rxst_sva (
   input logic       clk_i,
   input logic       rst_i,
   input logic       en_i,
   input logic       lock_i,
   input logic       eb_fault_i,
   input logic       char_valid_i,
   input logic [2:0] status_o,
   input logic       err_o,
   input logic       match_o
);
   assert_off_code_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (status_o == 3'b111) && !err_o && !match_o);

   assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      status_o inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b111});

   assert_one_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !(err_o && match_o));

   assert_pulse_needs_char_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (err_o || match_o) |-> $past(char_valid_i));

   assert_match_code_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      match_o |-> status_o inside {3'b010, 3'b100});

   assert_err_code_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      err_o |-> status_o inside {3'b011, 3'b001});

   assert_idle_keeps_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && lock_i && !eb_fault_i && !char_valid_i &&
       status_o inside {3'b010, 3'b011, 3'b100})
      |=> (status_o == $past(status_o)) && !err_o && !match_o);

   assert_lock_start_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !lock_i) |=> (status_o == 3'b000) && !err_o && !match_o);

   assert_fault_start_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && lock_i && eb_fault_i) |=> (status_o == 3'b000) && !err_o && !match_o);
endmodule

bind rx_selftest_monitor rxst_sva u_sva (
   .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .lock_i(lock_i),
   .eb_fault_i(eb_fault_i), .char_valid_i(char_valid_i),
   .status_o(status_o), .err_o(err_o), .match_o(match_o));

// File: tb/sim_rx_selftest_monitor.sv
`timescale 1ns/1ps
module sim_rx_selftest_monitor;
   logic       clk = 1'b0;
   logic       rst, en, lock, ebf, valid, ctl;
   logic [7:0] byte_in;
   logic [2:0] status;
   logic       err, match;
   int         total = 0;
   int         bad = 0;
   logic [8:0] bl;
   logic [10:0] v;
   logic [7:0] b;

   always #2 clk = ~clk;

   rx_selftest_monitor u0 (
      .clk_i(clk), .rst_i(rst), .en_i(en), .lock_i(lock), .eb_fault_i(ebf),
      .char_valid_i(valid), .char_ctl_i(ctl), .char_byte_i(byte_in),
      .status_o(status), .err_o(err), .match_o(match));

   localparam logic [8:0] SEED = 9'h100;

   function automatic logic [8:0] nx(input logic [8:0] s);
      return {s[7:0], s[8] ^ s[4]};
   endfunction

   // {en, lock, fault, valid, kind[1:0], status[2:0], err, match}
   // kind: 0 pattern char, 1 corrupted char, 2 start char, 3 filler 0x55
   localparam int NV = 17;
   localparam logic [10:0] VEC [NV] = '{
      11'b0_1_0_0_11_111_0_0,  // R1 disabled
      11'b1_1_0_0_11_000_0_0,  // R3 enable -> start
      11'b1_1_0_1_11_001_0_0,  // R3 char -> wait
      11'b1_1_0_1_11_001_0_0,  // R4 filler keeps wait
      11'b1_1_0_1_10_010_0_0,  // R4 start char
      11'b1_1_0_1_00_010_0_1,  // R6 match
      11'b1_1_0_1_00_010_0_1,  // R5 next pattern byte
      11'b1_1_0_1_01_011_1_0,  // R6 error
      11'b1_1_0_0_11_011_0_0,  // R6 idle cycle
      11'b1_1_0_1_00_010_0_1,  // R6 match again
      11'b1_1_0_1_01_011_1_0,  // R8 error
      11'b1_1_0_1_00_010_0_1,  // R8 match
      11'b1_0_0_0_11_000_0_0,  // R9 lock lost
      11'b1_1_0_1_11_001_0_0,  // R9 no hold after lock
      11'b1_1_0_1_10_010_0_0,  // R4 resync
      11'b1_1_0_1_00_010_0_1,  // R5 match
      11'b1_1_1_0_11_000_0_0   // R10 buffer fault
   };
   localparam int TAG [NV] = '{1, 3, 3, 4, 4, 6, 5, 6, 6, 6, 8, 8, 9, 9, 4, 5, 10};

   task automatic chk(input int r, input logic [2:0] st, input logic e, input logic m);
      total++;
      if (status !== st || err !== e || match !== m) begin
         bad++;
         $display("FAIL R%0d: status=%b err=%b match=%b expected status=%b err=%b match=%b",
                  r, status, err, match, st, e, m);
      end
   endtask

   task automatic cyc(input logic e, input logic l, input logic f, input logic vl,
                      input logic k, input logic [7:0] d);
      en = e; lock = l; ebf = f; valid = vl; ctl = k; byte_in = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pat;
      cyc(1, 1, 0, 1, 0, bl[7:0]);
      bl = nx(bl);
   endtask

   task automatic corrupt;
      cyc(1, 1, 0, 1, 0, bl[7:0] ^ 8'hFF);
      bl = nx(bl);
   endtask

   task automatic sync;
      cyc(1, 1, 0, 1, 0, 8'h00);
      bl = nx(SEED);
   endtask

   task automatic filler;
      cyc(1, 1, 0, 1, 0, 8'h55);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1; en = 0; lock = 1; ebf = 0; valid = 0; ctl = 0; byte_in = 0; bl = SEED;
      @(negedge clk);
      @(negedge clk);
      chk(1, 3'b111, 0, 0);  // R1 reset state
      rst = 0;

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         case (v[6:5])
            2'd0: begin b = bl[7:0]; bl = nx(bl); end
            2'd1: begin b = bl[7:0] ^ 8'hFF; bl = nx(bl); end
            2'd2: begin b = 8'h00; bl = nx(SEED); end
            default: b = 8'h55;
         endcase
         cyc(v[10], v[9], v[8], v[7], 1'b0, b);
         chk(TAG[i], v[4:2], v[1], v[0]);
      end

      // R10: idle cycles do not count, nine characters held, tenth releases
      repeat (3) cyc(1, 1, 0, 0, 0, 8'h55);
      chk(10, 3'b000, 0, 0);
      repeat (9) filler();
      chk(10, 3'b000, 0, 0);
      filler();
      chk(10, 3'b001, 0, 0);

      // R4: zero byte with control flag does not start compare
      cyc(1, 1, 0, 1, 1, 8'h00);
      chk(4, 3'b001, 0, 0);

      // R8: floor at zero after matches, then 17 errors to resync
      sync();
      repeat (5) pat();
      repeat (16) corrupt();
      chk(8, 3'b011, 1, 0);
      corrupt();
      chk(8, 3'b001, 1, 0);

      // R8: a match lowers the balance by one
      sync();
      repeat (16) corrupt();
      pat();
      chk(8, 3'b010, 0, 1);
      corrupt();
      chk(8, 3'b011, 1, 0);
      corrupt();
      chk(8, 3'b001, 1, 0);

      // R11: buffer fault beats the threshold crossing
      sync();
      repeat (16) corrupt();
      cyc(1, 1, 1, 1, 0, 8'hAA);
      chk(11, 3'b000, 0, 0);
      repeat (9) filler();
      chk(11, 3'b000, 0, 0);
      filler();
      chk(11, 3'b001, 0, 0);

      // R11: lock loss beats buffer fault, so no hold is loaded
      sync();
      cyc(1, 0, 1, 0, 0, 8'h55);
      chk(11, 3'b000, 0, 0);
      filler();
      chk(11, 3'b001, 0, 0);

      // R9: lock loss from wait, and staying low holds start
      cyc(1, 0, 0, 0, 0, 8'h55);
      chk(9, 3'b000, 0, 0);
      cyc(1, 0, 0, 1, 0, 8'h55);
      chk(9, 3'b000, 0, 0);
      filler();
      chk(9, 3'b001, 0, 0);

      // R7: full sequence wrap
      sync();
      repeat (509) pat();
      chk(7, 3'b010, 0, 1);
      pat();
      chk(7, 3'b100, 0, 1);
      total++;
      if (bl[7:0] !== 8'h00) begin
         bad++;
         $display("FAIL R5: byte after wrap=%h expected=00", bl[7:0]);
      end
      pat();
      chk(7, 3'b010, 0, 1);

      // R1: disable from compare, and disable clears a pending hold
      cyc(0, 1, 0, 0, 0, 8'h55);
      chk(1, 3'b111, 0, 0);
      cyc(1, 1, 0, 0, 0, 8'h55);
      chk(3, 3'b000, 0, 0);
      cyc(1, 1, 1, 0, 0, 8'h55);
      chk(10, 3'b000, 0, 0);
      cyc(0, 1, 0, 0, 0, 8'h55);
      chk(1, 3'b111, 0, 0);
      cyc(1, 1, 0, 0, 0, 8'h55);
      filler();
      chk(1, 3'b001, 0, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule